// File: doc/BRIEF.md
# Ring-Counter Memory Cycle Timer

This block paces a core-memory store. It divides the processor clock down to one memory cycle of 20 clocks. It does this with a one-hot ring of ten positions, and the ring moves one place every second clock. At the default 2 MHz clock, a cycle therefore lasts 10 µs and cycles repeat at 100 kHz. Inside each cycle the block drives three strobes for the address register: read, clear and write. Each strobe is held for three clocks (1.5 µs).

A client raises one or more request lines. The block looks at them only on the first clock of ring position 0, which is the first clock of a cycle. The request that wins sets the operation for the whole cycle:
- a plain read issues a read strobe and nothing else;
- a read-modify-write issues a read strobe and then a write strobe;
- a clear-write issues a clear strobe and then a write strobe.

The read or clear strobe covers clocks 1 to 3 of the cycle. The write strobe always starts on the first clock of position 5. A write is never issued unless a read or clear of the same cycle came before it.

If the ring ever holds anything other than exactly one set bit, it restarts at position 0.

The strobe controller has five states:
- IDLE waits for the sampling clock.
- READ and CLEAR each drive their strobe for three clocks.
- HOLD waits for position 5.
- WRITE drives the write strobe for three clocks.

Its transitions are:
- IDLE to READ, on a plain read or a read-modify-write at the sampling clock.
- IDLE to CLEAR, on a clear-write at the sampling clock.
- READ or CLEAR to HOLD, once the strobe ends and a write is pending.
- READ to IDLE, once the strobe ends and no write is pending.
- HOLD to WRITE, on the last clock of position 4.
- WRITE to IDLE, once the strobe ends.

Top module: `mct_cycle_timer`

## Requirements
In these requirements, clock k of a cycle counts from 0. Clock 0 is the first clock after reset is released, and the count wraps every 20 clocks. Position p holds clocks 2p and 2p+1. `phase_o` bit p is high during position p.
- R1: `phase_o` always has exactly one bit set. That bit is bit floor(k/2), so the position advances once every two clocks and wraps from 9 to 0.
- R2: `cyc_done_o` is high on clock 19 of every cycle and low on all other clocks.
- R3: Requests are sampled only on the clock edge that ends clock 0. Request levels present on any other clock have no effect on the strobes.
- R4: When several requests are present at the sampling edge, clear-write wins over read-modify-write, and read-modify-write wins over plain read.
- R5: A plain read drives `rd_stb_o` high on clocks 1 to 3. No write strobe follows in that cycle.
- R6: A read-modify-write drives `rd_stb_o` high on clocks 1 to 3 and `wr_stb_o` high on clocks 10 to 12.
- R7: A clear-write drives `clr_stb_o` high on clocks 1 to 3 and `wr_stb_o` high on clocks 10 to 12.
- R8: `wr_stb_o` is high only in a cycle where a read or clear strobe has already occurred. No two strobes are ever high together.
- R9: While `rst_n` is low, `phase_o` equals 1 and all strobes and `cyc_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_read_i | input | 1 | Request for a plain read |
| req_rmw_i | input | 1 | Request for a read-modify-write |
| req_clrwr_i | input | 1 | Request for a clear-write |
| phase_o | output | 10 | One-hot ring position |
| rd_stb_o | output | 1 | Read strobe |
| clr_stb_o | output | 1 | Clear strobe |
| wr_stb_o | output | 1 | Write strobe |
| cyc_done_o | output | 1 | High on the last clock of a cycle |

## Verification
All outputs come from registers, so each output changes one clock edge after the state that causes it. A request present at the edge that ends clock 0 shows up as a read or clear strobe on clocks 1 to 3 and as a write strobe on clocks 10 to 12. The cycle-complete pulse depends only on the ring, and appears on clock 19. The bench keeps its own count of the clock index and the captured operation, updated at each rising edge. It compares every output at the following falling edge, so each check looks at the clock that the requirement names.

// File: rtl/mct_pkg.sv
package mct_pkg;

    // Operation captured for one memory cycle
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_RMW   = 2'd2,
        OP_CLRWR = 2'd3
    } op_e;

    // Strobe controller states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_CLEAR = 3'd2,
        ST_HOLD  = 3'd3,
        ST_WRITE = 3'd4
    } st_e;

endpackage

// File: rtl/mct_ring.sv
module mct_ring #(
    parameter int POSITIONS    = 10,
    parameter int CLKS_PER_POS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [POSITIONS-1:0] ring_o,
    output logic                 pos_last_o,
    output logic                 cyc_first_o,
    output logic                 cyc_last_o
);

    localparam int PW = (CLKS_PER_POS > 1) ? $clog2(CLKS_PER_POS) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_POS - 1);
    localparam logic [POSITIONS-1:0] RING_HOME = POSITIONS'(1);

    logic [POSITIONS-1:0] ring_q;
    logic [PW-1:0]        pre_q;

    // Prescaler and one-hot ring; any illegal ring value restarts at home.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= RING_HOME;
            pre_q  <= '0;
        end else if (!$onehot(ring_q)) begin
            ring_q <= RING_HOME;
            pre_q  <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q  <= '0;
            ring_q <= {ring_q[POSITIONS-2:0], ring_q[POSITIONS-1]};
        end else begin
            pre_q  <= pre_q + PW'(1);
        end
    end

    assign ring_o      = ring_q;
    assign pos_last_o  = (pre_q == PRE_LAST);
    assign cyc_first_o = ring_q[0] && (pre_q == '0);
    assign cyc_last_o  = ring_q[POSITIONS-1] && (pre_q == PRE_LAST);

    // R1
    ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(ring_q));

    // R1
    ring_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_last_o |=> ring_q == {$past(ring_q[POSITIONS-2:0]), $past(ring_q[POSITIONS-1])});

    // R1
    ring_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pos_last_o |=> $stable(ring_q));

endmodule

// File: rtl/mct_strobe_fsm.sv
module mct_strobe_fsm
    import mct_pkg::*;
#(
    parameter int STROBE_CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_first_i,
    input  logic wr_start_i,
    input  logic req_read_i,
    input  logic req_rmw_i,
    input  logic req_clrwr_i,
    output logic rd_stb_o,
    output logic clr_stb_o,
    output logic wr_stb_o
);

    localparam int CW = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STROBE_CLKS - 1);

    st_e          st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          wr_pend_q, wr_pend_d;
    op_e           op_req;

    // Priority decode of the request lines
    always_comb begin
        if (req_clrwr_i)      op_req = OP_CLRWR;
        else if (req_rmw_i)   op_req = OP_RMW;
        else if (req_read_i)  op_req = OP_READ;
        else                  op_req = OP_NONE;
    end

    // Next-state logic
    always_comb begin
        st_d      = st_q;
        wr_pend_d = wr_pend_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cyc_first_i) begin
                    wr_pend_d = (op_req == OP_RMW) || (op_req == OP_CLRWR);
                    if (op_req == OP_CLRWR)
                        st_d = ST_CLEAR;
                    else if (op_req != OP_NONE)
                        st_d = ST_READ;
                end
            end
            ST_READ, ST_CLEAR: begin
                if (cnt_q == CNT_LAST)
                    st_d = wr_pend_q ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: begin
                if (wr_start_i)
                    st_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (cnt_q == CNT_LAST) begin
                    st_d      = ST_IDLE;
                    wr_pend_d = 1'b0;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register with strobe-length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            cnt_q     <= '0;
            wr_pend_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            wr_pend_q <= wr_pend_d;
            cnt_q     <= (st_d != st_q) ? '0 : cnt_q + CW'(1);
        end
    end

    // Outputs follow the state
    always_comb begin
        rd_stb_o  = 1'b0;
        clr_stb_o = 1'b0;
        wr_stb_o  = 1'b0;
        unique case (st_q)
            ST_READ:  rd_stb_o  = 1'b1;
            ST_CLEAR: clr_stb_o = 1'b1;
            ST_WRITE: wr_stb_o  = 1'b1;
            default: ;
        endcase
    end

    // Checker state: a read or clear has been seen in this cycle
    logic pre_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_seen_q <= 1'b0;
        else if (cyc_first_i)
            pre_seen_q <= 1'b0;
        else if (rd_stb_o || clr_stb_o)
            pre_seen_q <= 1'b1;
    end

    // R8
    wr_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> pre_seen_q);

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_stb_o, clr_stb_o, wr_stb_o}) <= 1);

    // R6
    wr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_stb_o) |-> $past(wr_start_i));

    // R3
    pre_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_stb_o || clr_stb_o) |-> $past(cyc_first_i));

endmodule

// File: rtl/mct_cycle_timer.sv
module mct_cycle_timer #(
    parameter int POSITIONS    = 10,
    parameter int CLKS_PER_POS = 2,
    parameter int STROBE_CLKS  = 3,
    parameter int WRITE_POS    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_read_i,
    input  logic                 req_rmw_i,
    input  logic                 req_clrwr_i,
    output logic [POSITIONS-1:0] phase_o,
    output logic                 rd_stb_o,
    output logic                 clr_stb_o,
    output logic                 wr_stb_o,
    output logic                 cyc_done_o
);

    logic [POSITIONS-1:0] ring;
    logic pos_last, cyc_first, cyc_last, wr_start;

    mct_ring #(
        .POSITIONS   (POSITIONS),
        .CLKS_PER_POS(CLKS_PER_POS)
    ) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_o     (ring),
        .pos_last_o (pos_last),
        .cyc_first_o(cyc_first),
        .cyc_last_o (cyc_last)
    );

    // Write begins on the first clock of the write position
    assign wr_start = ring[WRITE_POS-1] && pos_last;

    mct_strobe_fsm #(
        .STROBE_CLKS(STROBE_CLKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_first_i(cyc_first),
        .wr_start_i (wr_start),
        .req_read_i (req_read_i),
        .req_rmw_i  (req_rmw_i),
        .req_clrwr_i(req_clrwr_i),
        .rd_stb_o   (rd_stb_o),
        .clr_stb_o  (clr_stb_o),
        .wr_stb_o   (wr_stb_o)
    );

    assign phase_o    = ring;
    assign cyc_done_o = cyc_last;

    // R2
    done_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done_o |-> phase_o[POSITIONS-1]);

    // R2
    done_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done_o |=> phase_o[0] && !cyc_done_o);

    // R6
    wr_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_stb_o) |-> phase_o[WRITE_POS]);

endmodule

// File: tb/tb_mct_cycle_timer.sv
module tb_mct_cycle_timer;

    localparam int NPOS   = 10;
    localparam int CYC    = 20;
    localparam int NCYC   = 206;
    localparam int NDIR   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rq_rd = 1'b0, rq_rmw = 1'b0, rq_cw = 1'b0;
    logic [NPOS-1:0] phase;
    logic rd_stb, clr_stb, wr_stb, done;

    int errs = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mct_cycle_timer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_read_i (rq_rd),
        .req_rmw_i  (rq_rmw),
        .req_clrwr_i(rq_cw),
        .phase_o    (phase),
        .rd_stb_o   (rd_stb),
        .clr_stb_o  (clr_stb),
        .wr_stb_o   (wr_stb),
        .cyc_done_o (done)
    );

    // Operation codes: 0 none, 1 read, 2 read-modify-write, 3 clear-write
    function automatic int op_of(logic r, logic m, logic c);
        if (c) return 3;
        if (m) return 2;
        if (r) return 1;
        return 0;
    endfunction

    function automatic bit exp_rd(int op, int k);
        return (op == 1 || op == 2) && k >= 1 && k <= 3;
    endfunction

    function automatic bit exp_clr(int op, int k);
        return op == 3 && k >= 1 && k <= 3;
    endfunction

    function automatic bit exp_wr(int op, int k);
        return (op == 2 || op == 3) && k >= 10 && k <= 12;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int op;
        bit pre_seen;
        logic [2:0] dir_pat [NDIR];
        string tag;
        void'($urandom(32'hC0DE5EED));
        // {clear-write, rmw, read} presented at the sampling clock
        dir_pat[0] = 3'b000;  // R3: requests only off the sampling clock
        dir_pat[1] = 3'b001;  // R5
        dir_pat[2] = 3'b010;  // R6
        dir_pat[3] = 3'b100;  // R7
        dir_pat[4] = 3'b111;  // R4
        dir_pat[5] = 3'b011;  // R4
        op = 0;
        pre_seen = 1'b0;

        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", "phase in reset", int'(phase), 1);
        chk("R9", "strobes in reset", int'({rd_stb, clr_stb, wr_stb}), 0);
        chk("R9", "done in reset", int'(done), 0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            if (cyc == 0)                 tag = "R3";
            else if (cyc == 4 || cyc == 5) tag = "R4";
            else                          tag = "R5/R6/R7";
            for (int k = 0; k < CYC; k++) begin
                chk("R1", "phase", int'(phase), 1 << (k / 2));
                chk("R2", "cyc_done", int'(done), (k == CYC - 1) ? 1 : 0);
                chk(tag, "rd_stb",  int'(rd_stb),  int'(exp_rd(op, k)));
                chk(tag, "clr_stb", int'(clr_stb), int'(exp_clr(op, k)));
                chk(tag, "wr_stb",  int'(wr_stb),  int'(exp_wr(op, k)));
                if (k == 0) pre_seen = 1'b0;
                if (wr_stb) chk("R8", "write preceded", int'(pre_seen), 1);
                chk("R8", "strobe overlap",
                    ($countones({rd_stb, clr_stb, wr_stb}) > 1) ? 1 : 0, 0);
                if (rd_stb || clr_stb) pre_seen = 1'b1;

                if (cyc < NDIR) begin
                    if (k == 0)
                        {rq_cw, rq_rmw, rq_rd} = dir_pat[cyc];
                    else if (cyc == 0)
                        {rq_cw, rq_rmw, rq_rd} = 3'b111;
                    else
                        {rq_cw, rq_rmw, rq_rd} = 3'($urandom);
                end else begin
                    rq_rd  = ($urandom % 3) == 0;
                    rq_rmw = ($urandom % 3) == 0;
                    rq_cw  = ($urandom % 4) == 0;
                end

                @(posedge clk);
                if (k == 0) op = op_of(rq_rd, rq_rmw, rq_cw);
                @(negedge clk);
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule